// File: doc/BRIEF.md
# Shift-In Instruction Fetch Buffer

This block sits between the data phase of an instruction bus and the decode stage. When decode is stalled, fetched words keep arriving, and the buffer holds them together with a few bits of side information for each word: a bus error flag, bit 1 of the fetch address (needed later to align compressed instructions), and a two-bit prediction tag.

Every accepted word is written into row 0, so the path from the bus input to the storage register never passes through a write-pointer decoder. If row 0 already holds a word, all held words move one row deeper in the same cycle. Decode reads the deepest valid row, which is always the oldest word.

The buffer has three ports. The oldest-entry port feeds decode. The newest-entry port shows row 0, which a return-address predictor inspects. The update port lets that predictor rewrite the prediction tag of row 0 after the word has arrived. A synchronous flush empties the buffer in one cycle.

Top module: `fetch_shift_buf`

## Requirements
- R1: After reset, and in the cycle after a flush, `old_valid` and `new_valid` are low and `full` is low.
- R2: An accepted push places its word, error flag, address bit and prediction tag on the newest-entry outputs in the next cycle.
- R3: Words leave through the oldest-entry port in the order they were pushed, and held words are not altered when a later push shifts them deeper.
- R4: The oldest-entry outputs show the deepest valid row. `old_valid` is high whenever at least one row is held.
- R5: A push and a pop in the same cycle, with the buffer neither empty nor full, leave the number of held entries unchanged. The popped word is the oldest one, and the pushed word appears in row 0.
- R6: `full` is high exactly when DEPTH entries are held. A push while `full` is high is ignored, even when a pop is requested in the same cycle.
- R7: A pop while the buffer is empty is ignored. The buffer stays empty.
- R8: With `upd_en` high and row 0 valid, the prediction tag of row 0 becomes `upd_tag` in the next cycle, and its other fields are unchanged. With row 0 empty, the update has no effect on the next word pushed.
- R9: If an update and an accepted push occur in the same cycle, the update applies to the word that was in row 0 before the edge. That word carries the new tag into row 1 and keeps it until it leaves.
- R10: A flush takes priority over a push, a pop and an update in the same cycle. Afterwards the buffer is empty.
- R11: The error flag and the address bit of each entry travel unchanged from push to pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all entries |
| push_valid | input | 1 | A fetched word is offered |
| push_word | input | DW | Fetched instruction word |
| push_err | input | 1 | Bus error seen for this word |
| push_half | input | 1 | Bit 1 of the fetch address |
| push_tag | input | 2 | Prediction tag of the word |
| full | output | 1 | All DEPTH rows are held |
| pop | input | 1 | Decode takes the oldest entry |
| old_valid | output | 1 | Oldest-entry outputs are valid |
| old_word | output | DW | Oldest word |
| old_err | output | 1 | Error flag of the oldest word |
| old_half | output | 1 | Address bit of the oldest word |
| old_tag | output | 2 | Prediction tag of the oldest word |
| new_valid | output | 1 | Row 0 holds an entry |
| new_word | output | DW | Word in row 0 |
| new_err | output | 1 | Error flag in row 0 |
| new_half | output | 1 | Address bit in row 0 |
| new_tag | output | 2 | Prediction tag in row 0 |
| upd_en | input | 1 | Rewrite the prediction tag of row 0 |
| upd_tag | input | 2 | New prediction tag for row 0 |

## Verification
A wrong occupancy count shows up one cycle later as a wrong word on the oldest-entry port or as a wrong `full` level. A broken shift shows up as a duplicated or lost word on the oldest-entry port when the buffer is drained, which happens within DEPTH pops. A misrouted update shows up at once on `new_tag` when there is no push. When a push arrives in the same cycle, the misrouted update only shows once the affected word reaches the oldest-entry port. The bench runs a reference queue in parallel with the design and compares every output field after every edge, so a fault is reported in the cycle it first becomes visible.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    localparam int TAG_W = 2;

    typedef struct packed {
        logic             err;
        logic             half;
        logic [TAG_W-1:0] tag;
    } fsb_side_t;

    function automatic fsb_side_t fsb_retag(input fsb_side_t s,
                                            input logic en,
                                            input logic [TAG_W-1:0] t);
        fsb_side_t r;
        r = s;
        if (en) r.tag = t;
        return r;
    endfunction

endpackage

// File: rtl/fsb_ctrl.sv
module fsb_ctrl #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          do_push,
    output logic          shift_en,
    output logic          full,
    output logic [CW-1:0] occ
);
    logic do_pop;
    logic held;

    assign held     = (occ != '0);
    assign full     = (occ == CW'(DEPTH));
    assign do_push  = push_req && !full && !flush;
    assign do_pop   = pop_req && held && !flush;
    assign shift_en = do_push && held;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            occ <= '0;
        end else begin
            occ <= occ + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/fsb_rows.sv
module fsb_rows
    import fsb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        do_push,
    input  logic                        shift_en,
    input  logic                        upd_hit,
    input  logic [TAG_W-1:0]            upd_tag,
    input  logic [DW-1:0]               in_word,
    input  fsb_side_t                   in_side,
    output logic [DEPTH-1:0][DW-1:0]    row_word,
    output fsb_side_t [DEPTH-1:0]       row_side
);
    fsb_side_t head_side;

    assign head_side = fsb_retag(row_side[0], upd_hit, upd_tag);

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    row_word[0] <= '0;
                    row_side[0] <= '0;
                end else if (do_push) begin
                    row_word[0] <= in_word;
                    row_side[0] <= in_side;
                end else begin
                    row_side[0] <= head_side;
                end
            end
        end else if (i == 1) begin : g_second
            always_ff @(posedge clk) begin
                if (rst) begin
                    row_word[1] <= '0;
                    row_side[1] <= '0;
                end else if (shift_en) begin
                    row_word[1] <= row_word[0];
                    row_side[1] <= head_side;
                end
            end
        end else begin : g_deep
            always_ff @(posedge clk) begin
                if (rst) begin
                    row_word[i] <= '0;
                    row_side[i] <= '0;
                end else if (shift_en) begin
                    row_word[i] <= row_word[i-1];
                    row_side[i] <= row_side[i-1];
                end
            end
        end
    end
endmodule

// File: rtl/fsb_rdsel.sv
module fsb_rdsel
    import fsb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [CW-1:0]               occ,
    input  logic [DEPTH-1:0][DW-1:0]    row_word,
    input  fsb_side_t [DEPTH-1:0]       row_side,
    output logic [DW-1:0]               sel_word,
    output fsb_side_t                   sel_side
);
    logic [CW-1:0] last;
    logic [IW-1:0] idx;

    assign last = occ - CW'(1);
    assign idx  = IW'(last);

    always_comb begin
        sel_word = '0;
        sel_side = '0;
        if (occ != '0) begin
            sel_word = row_word[idx];
            sel_side = row_side[idx];
        end
    end
endmodule

// File: rtl/fetch_shift_buf.sv
module fetch_shift_buf
    import fsb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push_valid,
    input  logic [DW-1:0] push_word,
    input  logic          push_err,
    input  logic          push_half,
    input  logic [1:0]    push_tag,
    output logic          full,
    input  logic          pop,
    output logic          old_valid,
    output logic [DW-1:0] old_word,
    output logic          old_err,
    output logic          old_half,
    output logic [1:0]    old_tag,
    output logic          new_valid,
    output logic [DW-1:0] new_word,
    output logic          new_err,
    output logic          new_half,
    output logic [1:0]    new_tag,
    input  logic          upd_en,
    input  logic [1:0]    upd_tag
);
    localparam int CW = $clog2(DEPTH + 1);

    logic                     do_push;
    logic                     shift_en;
    logic [CW-1:0]            occ;
    logic                     upd_hit;
    fsb_side_t                in_side;
    logic [DEPTH-1:0][DW-1:0] row_word;
    fsb_side_t [DEPTH-1:0]    row_side;
    fsb_side_t                sel_side;

    assign in_side = '{err: push_err, half: push_half, tag: push_tag};
    assign upd_hit = upd_en && (occ != '0);

    fsb_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .push_req (push_valid),
        .pop_req  (pop),
        .do_push  (do_push),
        .shift_en (shift_en),
        .full     (full),
        .occ      (occ)
    );

    fsb_rows #(.DEPTH(DEPTH), .DW(DW)) rows_i (
        .clk      (clk),
        .rst      (rst),
        .do_push  (do_push),
        .shift_en (shift_en),
        .upd_hit  (upd_hit),
        .upd_tag  (upd_tag),
        .in_word  (push_word),
        .in_side  (in_side),
        .row_word (row_word),
        .row_side (row_side)
    );

    fsb_rdsel #(.DEPTH(DEPTH), .DW(DW)) rdsel_i (
        .occ      (occ),
        .row_word (row_word),
        .row_side (row_side),
        .sel_word (old_word),
        .sel_side (sel_side)
    );

    assign old_valid = (occ != '0);
    assign old_err   = sel_side.err;
    assign old_half  = sel_side.half;
    assign old_tag   = sel_side.tag;

    assign new_valid = (occ != '0);
    assign new_word  = row_word[0];
    assign new_err   = row_side[0].err;
    assign new_half  = row_side[0].half;
    assign new_tag   = row_side[0].tag;
endmodule

// File: rtl/fsb_checker.sv
module fsb_checker #(
    parameter int DEPTH = 4,
    parameter int DW    = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          push_valid,
    input logic [DW-1:0] push_word,
    input logic          pop,
    input logic          full,
    input logic          old_valid,
    input logic          new_valid,
    input logic [DW-1:0] new_word,
    input logic          upd_en,
    input logic [1:0]    upd_tag,
    input logic [1:0]    new_tag,
    input logic [CW-1:0] occ
);
    a_r1_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ == '0) && !old_valid && !full);

    a_r2_push_lands_row0: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !full && !flush) |=> new_valid && (new_word == $past(push_word)));

    a_r3_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !full && !pop && !flush) |=> (occ == $past(occ) + CW'(1)));

    a_r5_push_pop_steady: assert property (@(posedge clk) disable iff (rst)
        (push_valid && pop && old_valid && !full && !flush) |=> (occ == $past(occ)));

    a_r6_full_blocks_push: assert property (@(posedge clk) disable iff (rst)
        (full && push_valid && !pop && !flush) |=> full && (new_word == $past(new_word)));

    a_r7_empty_pop_ignored: assert property (@(posedge clk) disable iff (rst)
        (!old_valid && pop && !push_valid && !flush) |=> !old_valid);

    a_r8_retag_row0: assert property (@(posedge clk) disable iff (rst)
        (new_valid && upd_en && !push_valid && !flush) |=> (new_tag == $past(upd_tag)));
endmodule

bind fetch_shift_buf fsb_checker #(.DEPTH(DEPTH), .DW(DW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .push_valid (push_valid),
    .push_word  (push_word),
    .pop        (pop),
    .full       (full),
    .old_valid  (old_valid),
    .new_valid  (new_valid),
    .new_word   (new_word),
    .upd_en     (upd_en),
    .upd_tag    (upd_tag),
    .new_tag    (new_tag),
    .occ        (occ)
);

// File: tb/fetch_shift_buf_tb_top.sv
`timescale 1ns/1ps
module fetch_shift_buf_tb_top;
    localparam int D  = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_word = '0;
    logic          push_err = 1'b0;
    logic          push_half = 1'b0;
    logic [1:0]    push_tag = '0;
    logic          full;
    logic          pop = 1'b0;
    logic          old_valid;
    logic [DW-1:0] old_word;
    logic          old_err, old_half;
    logic [1:0]    old_tag;
    logic          new_valid;
    logic [DW-1:0] new_word;
    logic          new_err, new_half;
    logic [1:0]    new_tag;
    logic          upd_en = 1'b0;
    logic [1:0]    upd_tag = '0;

    always #4 clk = ~clk;

    fetch_shift_buf #(.DEPTH(D), .DW(DW)) dut_i (.*);

    int vectors = 0;
    int errors  = 0;

    logic [DW-1:0] md [D];
    logic          mf [D];
    logic          mh [D];
    logic [1:0]    mp [D];
    int            mcnt = 0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "R4 old_valid", 64'(old_valid), 64'(mcnt > 0));
        chk(tag, "R1 new_valid", 64'(new_valid), 64'(mcnt > 0));
        chk(tag, "R6 full", 64'(full), 64'(mcnt == D));
        if (mcnt > 0) begin
            chk(tag, "R4 old_word", 64'(old_word), 64'(md[mcnt-1]));
            chk(tag, "R11 old_err", 64'(old_err), 64'(mf[mcnt-1]));
            chk(tag, "R11 old_half", 64'(old_half), 64'(mh[mcnt-1]));
            chk(tag, "R9 old_tag", 64'(old_tag), 64'(mp[mcnt-1]));
            chk(tag, "R2 new_word", 64'(new_word), 64'(md[0]));
            chk(tag, "R2 new_err", 64'(new_err), 64'(mf[0]));
            chk(tag, "R2 new_half", 64'(new_half), 64'(mh[0]));
            chk(tag, "R8 new_tag", 64'(new_tag), 64'(mp[0]));
        end
    endtask

    task automatic step(input string tag, input bit p, input logic [DW-1:0] d,
                        input bit f, input bit h, input logic [1:0] t,
                        input bit po, input bit fl, input bit ue, input logic [1:0] ut);
        bit dp, dq;
        @(negedge clk);
        push_valid = p; push_word = d; push_err = f; push_half = h; push_tag = t;
        pop = po; flush = fl; upd_en = ue; upd_tag = ut;
        @(posedge clk);
        if (fl) begin
            mcnt = 0;
        end else begin
            dp = p && (mcnt < D);
            dq = po && (mcnt > 0);
            if (ue && mcnt > 0) mp[0] = ut;
            if (dp) begin
                for (int i = D - 1; i > 0; i--) begin
                    md[i] = md[i-1]; mf[i] = mf[i-1]; mh[i] = mh[i-1]; mp[i] = mp[i-1];
                end
                md[0] = d; mf[0] = f; mh[0] = h; mp[0] = t;
            end
            mcnt = mcnt + int'(dp) - int'(dq);
        end
        #1;
        compare(tag);
    endtask

    initial begin
        int guard = 0;
        while (guard < 150000) begin
            @(posedge clk);
            guard++;
        end
        errors++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        for (int i = 0; i < D; i++) begin
            md[i] = '0; mf[i] = 0; mh[i] = 0; mp[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare("R1");

        // R2 / R3 / R11: fill three words, then drain in order
        step("R2", 1, 32'h1111_0001, 1, 0, 2'd1, 0, 0, 0, 2'd0);
        step("R2", 1, 32'h2222_0002, 0, 1, 2'd2, 0, 0, 0, 2'd0);
        step("R11", 1, 32'h3333_0003, 1, 1, 2'd3, 0, 0, 0, 2'd0);
        step("R3", 0, '0, 0, 0, 2'd0, 1, 0, 0, 2'd0);
        step("R3", 0, '0, 0, 0, 2'd0, 1, 0, 0, 2'd0);
        step("R3", 0, '0, 0, 0, 2'd0, 1, 0, 0, 2'd0);
        // R7: pop on empty
        step("R7", 0, '0, 0, 0, 2'd0, 1, 0, 0, 2'd0);
        // R8: update while empty has no effect on next push
        step("R8", 0, '0, 0, 0, 2'd0, 0, 0, 1, 2'd3);
        step("R8", 1, 32'hAAAA_0000, 0, 0, 2'd0, 0, 0, 0, 2'd0);
        step("R8", 0, '0, 0, 0, 2'd0, 0, 0, 1, 2'd2);
        // R9: update with push, tag rides into row 1
        step("R9", 1, 32'hBBBB_0000, 0, 1, 2'd1, 0, 0, 1, 2'd3);
        // R6: fill, push at full ignored, also with pop
        step("R6", 1, 32'hCCCC_0000, 1, 0, 2'd0, 0, 0, 0, 2'd0);
        step("R6", 1, 32'hDDDD_0000, 0, 0, 2'd1, 0, 0, 0, 2'd0);
        step("R6", 1, 32'hEEEE_0000, 1, 1, 2'd2, 0, 0, 0, 2'd0);
        step("R6", 1, 32'hFFFF_0000, 1, 1, 2'd2, 1, 0, 0, 2'd0);
        // R5: push and pop at partial occupancy
        step("R5", 1, 32'h5555_0005, 0, 1, 2'd1, 1, 0, 0, 2'd0);
        step("R9", 0, '0, 0, 0, 2'd0, 1, 0, 0, 2'd0);
        step("R9", 0, '0, 0, 0, 2'd0, 1, 0, 0, 2'd0);
        // R10: flush beats push, pop and update
        step("R10", 1, 32'h7777_0007, 1, 1, 2'd3, 1, 1, 1, 2'd1);
        step("R1", 1, 32'h8888_0008, 0, 0, 2'd2, 0, 0, 0, 2'd0);
        step("R1", 0, '0, 0, 0, 2'd0, 0, 1, 0, 2'd0);

        // near-exhaustive random sweep of control combinations
        lf = 32'hACE1_2345;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step("R5", lf[0] | lf[9], lf ^ 32'(n), lf[2], lf[3], lf[5:4],
                 lf[6] & ~lf[12], lf[11:7] == 5'd0, lf[13], lf[15:14]);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule